// File: doc/BRIEF.md
# Packet Length Checker and Filter

This block sits on a 32-bit stream of length-prefixed packets. It reads the word count from the first word of each packet and compares that count with the number of words that actually arrive before the incoming end-of-packet flag. A packet whose two counts agree is forwarded downstream unchanged. On the forwarded packet the end-of-packet flag is rebuilt from the header count, not copied from the input.

A packet whose counts disagree is removed whole, and none of its words reach the output. A packet whose header count is zero or larger than the buffer is removed in the same way. Each packet is held in an internal buffer of 2^SIZE words until its final word has been checked. When the buffer is full, the upstream ready is withdrawn.

A sticky error flag reports that at least one packet was removed. The flag stays set until reset or until a one-cycle synchronous clear.

Top module: `pkt_len_filter`

## Requirements
- R1: The word count of a packet is bits [15:0] of its first word, and the count includes that first word. A packet whose input last flag arrives on exactly word number count is forwarded in order, with every data word intact.
- R2: On a forwarded packet, m_tlast_o is 1 on the word where the header count runs out and 0 on every other word.
- R3: If the input last flag arrives before the header count runs out, no word of that packet appears on the output.
- R4: If the header count runs out on a word whose input last flag is 0, the packet is removed. Every further input word up to and including the next word with last set is accepted and discarded.
- R5: A header count of 0 or greater than 2^SIZE removes the packet. If the header word does not carry last, the input is then discarded up to and including the next word with last set.
- R6: No word of a packet is offered on the output before its final word has been accepted. m_tvalid_o rises only in the cycle after an input transfer.
- R7: s_tready_o is 0 while the buffer holds 2^SIZE words, and 1 otherwise. It is always 1 while the rest of a removed packet is being discarded.
- R8: bus_error_o rises in the cycle after any removal and stays 1 until reset or clear_i. When clear_i and a removal fall in the same cycle, clear_i wins.
- R9: After reset, s_tready_o is 1, m_tvalid_o is 0 and bus_error_o is 0.
- R10: While m_tvalid_o is 1 and m_tready_i is 0, the output word and its last flag hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the error flag |
| s_tdata_i | input | 32 | Input stream data |
| s_tlast_i | input | 1 | Input end-of-packet flag |
| s_tvalid_i | input | 1 | Input valid |
| s_tready_o | output | 1 | Input ready |
| m_tdata_o | output | 32 | Output stream data |
| m_tlast_o | output | 1 | Output end-of-packet flag, rebuilt from the header count |
| m_tvalid_o | output | 1 | Output valid |
| m_tready_i | input | 1 | Output ready |
| bus_error_o | output | 1 | Sticky flag: a packet was removed |

## Verification
The bench covers these corner cases and the failure each one would expose:
- **Single-word packet:** a design that mishandles it would drop the packet or never mark its last word.
- **Packet exactly as long as the buffer:** an off-by-one full test would deadlock on it or overwrite the unread word at the read pointer.
- **Early input last flag:** a design that forgets to rewind would leak the stored words of the packet to the output.
- **Overlong packet:** a design that skips the drain state would read the tail of that packet as a new header.
- **Zero and oversized header counts:** a design that fails to catch these would stall or forward garbage.
- **Heavy output backpressure:** the bench checks that upstream ready falls while the buffer is full.
- **Clear during activity:** the bench checks that the error flag returns to zero on clear.

// File: rtl/plf_pkg.sv
package plf_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 16;

  typedef enum logic [1:0] {
    ST_HEAD  = 2'd0,
    ST_BODY  = 2'd1,
    ST_DRAIN = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic              last;
    logic [DATA_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/plf_len_fsm.sv
module plf_len_fsm
  import plf_pkg::*;
#(
  parameter int unsigned SIZE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [LEN_W-1:0] hdr_len_i,
  input  logic             last_i,
  output logic             wr_o,
  output logic             wr_last_o,
  output logic             commit_o,
  output logic             drop_o,
  output logic             drain_o
);
  localparam logic [LEN_W:0] MAX_LEN = (LEN_W+1)'(2**SIZE);

  rx_state_e        state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             len_bad, fin;

  assign len_bad = (hdr_len_i == '0) || ({1'b0, hdr_len_i} > MAX_LEN);
  // word that exhausts the header count
  assign fin     = (state_q == ST_HEAD) ? (hdr_len_i == LEN_W'(1)) : (rem_q == LEN_W'(1));
  assign drain_o = (state_q == ST_DRAIN);

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    wr_o      = 1'b0;
    wr_last_o = 1'b0;
    commit_o  = 1'b0;
    drop_o    = 1'b0;
    if (beat_i) begin
      if (state_q == ST_DRAIN) begin
        if (last_i) state_d = ST_HEAD;
      end else if (state_q == ST_HEAD && len_bad) begin
        drop_o  = 1'b1;
        state_d = last_i ? ST_HEAD : ST_DRAIN;
      end else if (fin) begin
        if (last_i) begin
          wr_o      = 1'b1;
          wr_last_o = 1'b1;
          commit_o  = 1'b1;
          state_d   = ST_HEAD;
        end else begin
          drop_o  = 1'b1;
          state_d = ST_DRAIN;
        end
      end else if (last_i) begin
        drop_o  = 1'b1;
        state_d = ST_HEAD;
      end else begin
        wr_o    = 1'b1;
        state_d = ST_BODY;
        rem_d   = ((state_q == ST_HEAD) ? hdr_len_i : rem_q) - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HEAD;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end
endmodule

// File: rtl/plf_store.sv
module plf_store
  import plf_pkg::*;
#(
  parameter int unsigned SIZE = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  beat_t wr_beat_i,
  input  logic  commit_i,
  input  logic  rewind_i,
  input  logic  pop_i,
  output logic  full_o,
  output logic  avail_o,
  output beat_t rd_beat_o
);
  localparam int unsigned DEPTH = 2**SIZE;
  localparam int unsigned PW    = SIZE + 1;

  beat_t         mem [DEPTH];
  logic [PW-1:0] wptr_q, cptr_q, rptr_q;

  assign full_o    = (wptr_q - rptr_q) == PW'(DEPTH);
  assign avail_o   = (rptr_q != cptr_q);
  assign rd_beat_o = mem[rptr_q[SIZE-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wptr_q[SIZE-1:0]] <= wr_beat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cptr_q <= '0;
      rptr_q <= '0;
    end else begin
      // rewind and write never coincide
      if (rewind_i)  wptr_q <= cptr_q;
      else if (wr_i) wptr_q <= wptr_q + PW'(1);
      if (commit_i)  cptr_q <= wptr_q + PW'(1);
      if (pop_i)     rptr_q <= rptr_q + PW'(1);
    end
  end
endmodule

// File: rtl/plf_sticky.sv
module plf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/pkt_len_filter.sv
module pkt_len_filter
  import plf_pkg::*;
#(
  parameter int unsigned SIZE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tlast_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tlast_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              bus_error_o
);
  logic  beat, wr, wr_last, commit, drop, drain, full, avail;
  beat_t wr_beat, rd_beat;

  assign s_tready_o   = drain | ~full;
  assign beat         = s_tvalid_i & s_tready_o;
  assign wr_beat.last = wr_last;
  assign wr_beat.data = s_tdata_i;
  assign m_tvalid_o   = avail;
  assign m_tdata_o    = rd_beat.data;
  assign m_tlast_o    = rd_beat.last;

  plf_len_fsm #(.SIZE(SIZE)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .hdr_len_i (s_tdata_i[LEN_W-1:0]),
    .last_i    (s_tlast_i),
    .wr_o      (wr),
    .wr_last_o (wr_last),
    .commit_o  (commit),
    .drop_o    (drop),
    .drain_o   (drain)
  );

  plf_store #(.SIZE(SIZE)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_beat_i (wr_beat),
    .commit_i  (commit),
    .rewind_i  (drop),
    .pop_i     (avail & m_tready_i),
    .full_o    (full),
    .avail_o   (avail),
    .rd_beat_o (rd_beat)
  );

  plf_sticky u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (drop),
    .clr_i  (clear_i),
    .flag_o (bus_error_o)
  );
endmodule

// File: rtl/pkt_len_filter_sva.sv
module pkt_len_filter_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clear_i,
  input logic        s_tvalid_i,
  input logic        s_tready_o,
  input logic [31:0] m_tdata_o,
  input logic        m_tlast_o,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic        bus_error_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_error_o && !clear_i) |=> bus_error_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !bus_error_o);

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_error_o) |-> $past(s_tvalid_i && s_tready_o));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_tvalid_o) |-> $past(s_tvalid_i && s_tready_o));
endmodule

bind pkt_len_filter pkt_len_filter_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .s_tvalid_i  (s_tvalid_i),
  .s_tready_o  (s_tready_o),
  .m_tdata_o   (m_tdata_o),
  .m_tlast_o   (m_tlast_o),
  .m_tvalid_o  (m_tvalid_o),
  .m_tready_i  (m_tready_i),
  .bus_error_o (bus_error_o)
);

// File: tb/pkt_len_filter_test.sv
`timescale 1ns/1ps
module pkt_len_filter_test;
  localparam int SIZE  = 4;
  localparam int DEPTH = 2**SIZE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tlast = 1'b0, s_tvalid = 1'b0, m_tready = 1'b0;
  logic        s_tready, m_tlast, m_tvalid, bus_error;
  logic [31:0] m_tdata;

  always #4 clk = ~clk;

  pkt_len_filter #(.SIZE(SIZE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .s_tdata_i(s_tdata), .s_tlast_i(s_tlast), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tlast_o(m_tlast), .m_tvalid_o(m_tvalid), .m_tready_i(m_tready),
    .bus_error_o(bus_error)
  );

  int checks = 0, failures = 0;
  int good_words = 0, out_words = 0, seq = 0;
  bit saw_stall = 0;
  bit [32:0] txq[$];
  // reference model
  bit [32:0] m_pend[$], m_outq[$];
  int m_st = 0, m_rem = 0;
  bit m_err = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_pkt(int hdr, int n);
    for (int i = 0; i < n; i++) begin
      bit [31:0] d;
      d = (i == 0) ? {8'hC3, seq[7:0], hdr[15:0]} : $urandom;
      txq.push_back({(i == n-1), d});
    end
    if (hdr == n && hdr >= 1 && hdr <= DEPTH) good_words += n;
    seq++;
  endtask

  task automatic model_step(bit fin, bit [32:0] w, bit fout, bit clr);
    bit ev = 0;
    int len;
    if (fout) void'(m_outq.pop_front());
    if (fin) begin
      len = int'(w[15:0]);
      if (m_st == 2) begin
        if (w[32]) m_st = 0;
      end else if (m_st == 0 && (len == 0 || len > DEPTH)) begin
        ev = 1; m_st = w[32] ? 0 : 2;
      end else begin
        if (m_st == 0) m_rem = len;
        if (m_rem == 1 && w[32]) begin
          m_pend.push_back({1'b1, w[31:0]});
          foreach (m_pend[i]) m_outq.push_back(m_pend[i]);
          m_pend.delete(); m_st = 0;
        end else if (m_rem == 1) begin
          ev = 1; m_st = 2;
        end else if (w[32]) begin
          ev = 1; m_st = 0;
        end else begin
          m_pend.push_back({1'b0, w[31:0]}); m_rem--; m_st = 1;
        end
      end
    end
    if (ev) m_pend.delete();
    m_err = clr ? 1'b0 : (m_err | ev);
  endtask

  task automatic cycle(int vpct, int rpct, bit clr);
    bit e_rdy, e_val, fin, fout;
    bit [32:0] w;
    @(negedge clk);
    e_rdy = (m_st == 2) || (m_pend.size() + m_outq.size() < DEPTH);
    e_val = m_outq.size() > 0;
    chk(s_tready === e_rdy, "R7", "s_tready", s_tready, e_rdy);
    chk(m_tvalid === e_val, "R6", "m_tvalid", m_tvalid, e_val);
    if (e_val) begin
      chk(m_tdata === m_outq[0][31:0], "R1", "m_tdata", m_tdata, m_outq[0][31:0]);
      chk(m_tlast === m_outq[0][32], "R2", "m_tlast", m_tlast, m_outq[0][32]);
    end
    chk(bus_error === m_err, "R8", "bus_error", bus_error, m_err);
    if (!e_rdy && txq.size() > 0) saw_stall = 1;
    w = (txq.size() > 0) ? txq[0] : '0;
    s_tvalid = (txq.size() > 0) && ($urandom_range(99) < vpct);
    s_tdata  = w[31:0];
    s_tlast  = w[32];
    m_tready = ($urandom_range(99) < rpct);
    clear    = clr;
    fin  = s_tvalid && e_rdy;
    fout = m_tready && m_tvalid;
    if (fin) void'(txq.pop_front());
    if (fout) out_words++;
    model_step(fin, w, m_tready && e_val, clr);
  endtask

  task automatic drain(int vpct, int rpct);
    while (txq.size() > 0 || m_outq.size() > 0) cycle(vpct, rpct, 1'b0);
    repeat (3) cycle(0, rpct, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(s_tready === 1'b1, "R9", "reset s_tready", s_tready, 1);
    chk(m_tvalid === 1'b0, "R9", "reset m_tvalid", m_tvalid, 0);
    chk(bus_error === 1'b0, "R9", "reset bus_error", bus_error, 0);

    // R1 R2: lengths 1, 2, 5 and a full-buffer packet
    push_pkt(1, 1); push_pkt(2, 2); push_pkt(5, 5); push_pkt(DEPTH, DEPTH);
    drain(100, 100);
    chk(out_words == good_words, "R1", "word total", out_words, good_words);
    chk(bus_error === 1'b0, "R1", "no error on good", bus_error, 0);

    // R3: early last
    push_pkt(6, 3); push_pkt(3, 3);
    drain(100, 100);
    chk(out_words == good_words, "R3", "word total", out_words, good_words);
    chk(bus_error === 1'b1, "R3", "error set", bus_error, 1);

    // R8: clear
    cycle(0, 100, 1'b1);
    cycle(0, 100, 1'b0);
    chk(bus_error === 1'b0, "R8", "cleared", bus_error, 0);

    // R4: missing last, tail discarded
    push_pkt(3, 6); push_pkt(4, 4);
    drain(100, 100);
    chk(out_words == good_words, "R4", "word total", out_words, good_words);
    chk(bus_error === 1'b1, "R4", "error set", bus_error, 1);
    cycle(0, 100, 1'b1);

    // R5: zero and oversized counts
    push_pkt(0, 3); push_pkt(DEPTH + 1, DEPTH + 1); push_pkt(40, 1); push_pkt(2, 2);
    drain(100, 100);
    chk(out_words == good_words, "R5", "word total", out_words, good_words);
    chk(bus_error === 1'b1, "R5", "error set", bus_error, 1);
    cycle(0, 100, 1'b1);

    // R7: heavy backpressure
    saw_stall = 0;
    repeat (4) push_pkt(DEPTH, DEPTH);
    push_pkt(7, 7);
    drain(95, 15);
    chk(saw_stall == 1'b1, "R7", "stall observed", saw_stall, 1);
    chk(out_words == good_words, "R7", "word total", out_words, good_words);

    // R10 and mixed traffic
    for (int k = 0; k < 60; k++) begin
      int r, n;
      r = $urandom_range(9);
      n = $urandom_range(DEPTH, 1);
      if (r < 6)       push_pkt(n, n);
      else if (r == 6) push_pkt(n + 2, n);
      else if (r == 7) push_pkt(n, n + 2);
      else if (r == 8) push_pkt(0, n);
      else             push_pkt(DEPTH + 5, n);
    end
    drain(70, 55);
    chk(out_words == good_words, "R10", "word total mixed", out_words, good_words);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule